// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block folds five reset requests into one internal reset for a small controller-class system. The requests are power-on, an active-low external pin, watchdog expiry, brown-out and a debug-chain reset bit. Power-on, watchdog and debug requests force the reset output high straight away, whether or not the clock is running. The external pin and the brown-out request first pass a sample filter of their own. Once every request has gone quiet, a release counter runs for a selectable number of clocks. Its result then passes through two synchronizing flops before the reset output drops.

A five-bit cause register records which request caused the reset. A bit stays set until software clears it through a simple write port. Writing 0 to a bit clears it, and writing 1 leaves it as it is.

Top module: `rst_seq`

## Requirements
- R1: While `por_req`, `wdt_req` or `dbg_req` is high, `rst_out` is high. It rises in the same time step as the request, with no clock edge needed.
- R2: `rst_out` stays high while any accepted request is active: power-on, watchdog, debug, a filtered external request or a filtered brown-out request.
- R3: `dly_sel` sets the release length L: 2'b00 gives 4 clocks, 2'b01 gives 64, 2'b10 gives 1024 and 2'b11 gives 16384. Say the last direct request (power-on, watchdog or debug) is removed between two edges. Then `rst_out` is seen low after exactly L+2 rising edges, and not before.
- R4: An accepted request that appears while the release count is running restarts the count from zero. After that request is removed, the release again takes L+2 edges.
- R5: The debug request keeps `rst_out` high for every cycle that `dbg_req` is 1.
- R6: A brown-out request is accepted only when `bod_en` is 1 and `bod_req` has been sampled high at 4 consecutive rising edges. Three samples cause no reset, and with `bod_en` at 0 the request causes no reset at all.
- R7: The external pin is accepted after `ext_rst_n` has been sampled low at 4 consecutive rising edges, and `rst_out` then rises. A low pulse of 3 samples causes no reset and sets no cause bit.
- R8: The bits of `cause` are [0] power-on, [1] external, [2] brown-out, [3] watchdog and [4] debug. A bit is set at each rising edge where its request is accepted, and it stays set until it is cleared.
- R9: At a rising edge with `wr_en` at 1, each `cause` bit whose `wr_data` bit is 0 is cleared, and each bit whose `wr_data` bit is 1 keeps its value. A request accepted at the same edge wins over the clear.
- R10: `por_req` sets `cause` to 5'b00001 and clears both filters, all without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin level, active low |
| wdt_req | input | 1 | Watchdog expiry request, active high |
| bod_req | input | 1 | Digitized brown-out comparator output, active high |
| bod_en | input | 1 | Brown-out detector enable |
| dbg_req | input | 1 | Debug-chain reset bit |
| dly_sel | input | 2 | Release delay select |
| wr_en | input | 1 | Cause register write strobe |
| wr_data | input | 5 | Write data; a 0 clears the matching cause bit |
| rst_out | output | 1 | Internal reset, active high |
| cause | output | 5 | Sticky reset cause flags |

## Verification
The assertions take for granted that request levels and the write port change away from the rising clock edge, so each edge samples one settled value. They also assume that `dly_sel` is held steady while a release count is running. They are disabled while power-on is active, because that input rewrites the whole state. The stimulus changes every input two nanoseconds after a falling edge and changes `dly_sel` only while a direct request holds the block in reset. The cycle model in the bench relies on the same timing.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int EXT_MIN      = 4,
  parameter int BOD_MIN      = 4,
  parameter int DLY_BASE_LOG = 2,
  parameter int DLY_STEP_LOG = 4
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       ext_rst_n,
  input  logic       wdt_req,
  input  logic       bod_req,
  input  logic       bod_en,
  input  logic       dbg_req,
  input  logic [1:0] dly_sel,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  output logic       rst_out,
  output logic [4:0] cause
);
  localparam int CW = DLY_BASE_LOG + 3 * DLY_STEP_LOG + 1;
  localparam int EW = $clog2(EXT_MIN + 1);
  localparam int BW = $clog2(BOD_MIN + 1);

  logic [EW-1:0] ext_cnt;
  logic [BW-1:0] bod_cnt;
  logic [CW-1:0] dly_cnt;
  logic [CW-1:0] dly_lim;
  logic [1:0]    rel_q;
  logic          ext_ok, bod_ok, any_req, dly_done;

  assign ext_ok   = (ext_cnt == EW'(EXT_MIN));
  assign bod_ok   = (bod_cnt == BW'(BOD_MIN));
  assign any_req  = por_req | wdt_req | dbg_req | ext_ok | bod_ok;
  assign dly_lim  = CW'(1) << (DLY_BASE_LOG + DLY_STEP_LOG * int'(dly_sel));
  assign dly_done = (dly_cnt >= dly_lim);
  assign rst_out  = ~rel_q[1];

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)     ext_cnt <= '0;
    else if (ext_rst_n) ext_cnt <= '0;
    else if (!ext_ok)   ext_cnt <= ext_cnt + 1'b1;
  end

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)                bod_cnt <= '0;
    else if (!(bod_req && bod_en)) bod_cnt <= '0;
    else if (!bod_ok)              bod_cnt <= bod_cnt + 1'b1;
  end

  always_ff @(posedge clk or posedge any_req) begin
    if (any_req) begin
      dly_cnt <= '0;
      rel_q   <= 2'b00;
    end else begin
      if (!dly_done) dly_cnt <= dly_cnt + 1'b1;
      rel_q <= {rel_q[0], dly_done};
    end
  end

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) cause <= 5'b00001;
    else cause <= (cause & (wr_en ? wr_data : 5'b11111))
                | {dbg_req, wdt_req, bod_ok, ext_ok, 1'b0};
  end
endmodule

module rst_seq_chk (
  input logic       clk,
  input logic       por_req,
  input logic       wdt_req,
  input logic       dbg_req,
  input logic       bod_en,
  input logic       wr_en,
  input logic [4:0] wr_data,
  input logic       rst_out,
  input logic [4:0] cause
);
  a_r1_wdt_holds_reset: assert property (@(posedge clk) disable iff (por_req)
    wdt_req |-> rst_out);
  a_r5_dbg_holds_reset: assert property (@(posedge clk) disable iff (por_req)
    dbg_req |-> rst_out);
  a_r3_release_after_idle: assert property (@(posedge clk) disable iff (por_req)
    $fell(rst_out) |-> $past(!wdt_req && !dbg_req));
  a_r8_wdt_flag_set: assert property (@(posedge clk) disable iff (por_req)
    wdt_req |=> cause[3]);
  a_r8_wdt_flag_cause: assert property (@(posedge clk) disable iff (por_req)
    $rose(cause[3]) |-> $past(wdt_req));
  a_r8_dbg_flag_cause: assert property (@(posedge clk) disable iff (por_req)
    $rose(cause[4]) |-> $past(dbg_req));
  a_r6_bod_needs_enable: assert property (@(posedge clk) disable iff (por_req)
    $rose(cause[2]) |-> $past(bod_en, 2));
  a_r9_wdt_flag_clear: assert property (@(posedge clk) disable iff (por_req)
    (wr_en && !wr_data[3] && !wdt_req) |=> !cause[3]);
endmodule

bind rst_seq rst_seq_chk u_chk (.*);

// File: tb/rst_seq_tb.sv
module rst_seq_tb;
  localparam int EXT_MIN = 4;
  localparam int BOD_MIN = 4;

  logic clk = 0;
  logic por_req = 1, ext_rst_n = 1, wdt_req = 0, bod_req = 0, bod_en = 0, dbg_req = 0;
  logic [1:0] dly_sel = 2'b00;
  logic wr_en = 0;
  logic [4:0] wr_data = 5'b0;
  logic rst_out;
  logic [4:0] cause;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R10";

  int m_ext = 0, m_bod = 0, m_idle = 0;
  logic [4:0] m_cause = 5'b00001;
  bit eo, bo, pre, post;

  rst_seq u_dut (.clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .wdt_req(wdt_req),
    .bod_req(bod_req), .bod_en(bod_en), .dbg_req(dbg_req), .dly_sel(dly_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rst_out(rst_out), .cause(cause));

  always #4 clk = ~clk;

  function automatic int lim(input logic [1:0] s);
    case (s)
      2'b00: return 4;
      2'b01: return 64;
      2'b10: return 1024;
      default: return 16384;
    endcase
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    eo = (m_ext == EXT_MIN);
    bo = (m_bod == BOD_MIN);
    if (por_req) begin
      m_ext = 0; m_bod = 0; m_cause = 5'b00001; m_idle = 0;
    end else begin
      m_cause = (m_cause & (wr_en ? wr_data : 5'b11111)) | {dbg_req, wdt_req, bo, eo, 1'b0};
      m_ext = ext_rst_n ? 0 : (eo ? m_ext : m_ext + 1);
      m_bod = (bod_req && bod_en) ? (bo ? m_bod : m_bod + 1) : 0;
      pre  = wdt_req || dbg_req || eo || bo;
      post = wdt_req || dbg_req || (m_ext == EXT_MIN) || (m_bod == BOD_MIN);
      if (pre || post) m_idle = 0;
      else if (m_idle < 100000) m_idle++;
    end
  end

  always @(negedge clk) begin
    chk({cur_req, " rst_out model"}, int'(rst_out), int'(m_idle < lim(dly_sel) + 2));
    chk({cur_req, " cause model"}, int'(cause), int'(m_cause));
  end

  always @(posedge clk) if (cycles > 100000) begin
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic measure(input string r, input int exp);
    int n = 0;
    while (rst_out && n < 20000) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(r, n, exp);
    #2;
  endtask

  initial begin
    repeat (3) step();
    cur_req = "R10";
    chk("R10 reset held at power-on", int'(rst_out), 1);
    chk("R10 power-on cause", int'(cause), 5'b00001);
    por_req = 0;
    cur_req = "R3";
    measure("R3 release after power-on sel=00", 6);

    cur_req = "R1";
    step(); wdt_req = 1; #1;
    chk("R1 async assert by watchdog", int'(rst_out), 1);
    repeat (3) step();
    chk("R8 watchdog cause bit", int'(cause[3]), 1);
    wdt_req = 0;
    measure("R3 release after watchdog", 6);

    cur_req = "R9";
    step(); wr_en = 1; wr_data = 5'b10111;
    step(); wr_en = 0;
    chk("R9 clear only bit 3", int'(cause), 5'b00001);
    wdt_req = 1; wr_en = 1; wr_data = 5'b00000;
    step(); wr_en = 0;
    chk("R9 set wins over clear", int'(cause), 5'b01000);
    wdt_req = 0;
    measure("R3 release after clear test", 6);

    cur_req = "R7";
    ext_rst_n = 0; repeat (3) step(); ext_rst_n = 1;
    repeat (2) step();
    chk("R7 short pulse no reset", int'(rst_out), 0);
    chk("R7 short pulse no cause", int'(cause[1]), 0);
    ext_rst_n = 0; repeat (4) step();
    chk("R7 long pulse resets", int'(rst_out), 1);
    repeat (2) step();
    chk("R2 held while pin low", int'(rst_out), 1);
    ext_rst_n = 1;
    repeat (10) step();
    chk("R8 external cause bit", int'(cause[1]), 1);

    cur_req = "R6";
    bod_req = 1; repeat (8) step();
    chk("R6 disabled detector ignored", int'(rst_out), 0);
    bod_req = 0; bod_en = 1; step();
    bod_req = 1; repeat (3) step(); bod_req = 0; step();
    chk("R6 short dip ignored", int'(rst_out), 0);
    chk("R6 short dip no cause", int'(cause[2]), 0);
    bod_req = 1; repeat (4) step();
    chk("R6 long dip resets", int'(rst_out), 1);
    bod_req = 0; repeat (10) step();
    chk("R8 brown-out cause bit", int'(cause[2]), 1);

    cur_req = "R5";
    dbg_req = 1;
    for (int i = 0; i < 50; i++) begin
      step(); chk("R5 debug holds reset", int'(rst_out), 1);
    end
    dbg_req = 0;
    chk("R8 debug cause bit", int'(cause[4]), 1);
    measure("R3 release after debug", 6);

    cur_req = "R4";
    wdt_req = 1; dly_sel = 2'b01; step(); wdt_req = 0;
    repeat (30) step();
    chk("R4 still in reset mid-count", int'(rst_out), 1);
    wdt_req = 1; step(); wdt_req = 0;
    measure("R4 count restarted sel=01", 66);

    cur_req = "R3";
    wdt_req = 1; dly_sel = 2'b10; step(); wdt_req = 0;
    measure("R3 release sel=10", 1026);
    wdt_req = 1; dly_sel = 2'b11; step(); wdt_req = 0;
    measure("R3 release sel=11", 16386);

    cur_req = "R10";
    wdt_req = 1; dly_sel = 2'b00; step(); wdt_req = 0;
    measure("R3 release before power-on test", 6);
    por_req = 1; #1;
    chk("R10 async assert by power-on", int'(rst_out), 1);
    chk("R10 cause after power-on", int'(cause), 5'b00001);
    repeat (2) step(); por_req = 0;
    measure("R3 release after second power-on", 6);

    cur_req = "R9";
    wr_en = 1; wr_data = 5'b00000; step(); wr_en = 0;
    chk("R9 clear all", int'(cause), 5'b00000);
    repeat (3) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule